// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block produces up to two pulse-width modulated outputs, each set up through a small synchronous register port. Every channel has three registers: control, duty and period. The control register holds a clock divider setting and a stop-mode flag. The duty register holds a compare value and a force-on flag. The period register holds the length of the cycle in divided ticks. The input clock is first divided by a programmable prescaler. Each divided tick then advances a period counter. The output is active while that counter is below the duty compare value.

Software writes the registers while the channel is idle and then raises the channel's enable pin. New duty, period and prescale values written while the channel runs are held back until the current period ends, so the output never shows a truncated or stretched pulse. When the enable pin falls, the stop-mode flag decides what happens. With the flag set, the channel cuts the output off on the next clock. With the flag clear, the channel finishes the period it is in and then goes idle.

Top module: `pwm_prescaled`

## Requirements
- R1: Registers are word aligned. Within a channel, control is at offset 0x00, duty at 0x04 and period at 0x08. A read (rd_en high) returns on rdata, one clock later, the last value written. Bits that are not implemented read as zero: control keeps bits [6:0], duty keeps bits [10:0] and period keeps bits [9:0]. Any other address reads zero.
- R2: The registers of channel 1 sit at the channel 0 addresses plus 0x10. Writes to one channel leave the other channel's registers unchanged.
- R3: Control bits [5:0] hold the prescale value P, and the period register holds V. Each output period lasts (P+1)*(V+1) clocks. The first period begins in the clock after the rising edge of enable is sampled, and periods follow back to back while enable stays high.
- R4: Duty bits [9:0] hold the compare value D. The output is active (high) for the first (P+1)*D clocks of each period and inactive (low) for the rest.
- R5: When D is 0 and duty bit 10 is clear, the output stays low for the whole period.
- R6: When duty bit 10 is set, the output is high for the whole period, whatever D holds.
- R7: When D is greater than V, the output is high for the whole period.
- R8: When control bit 6 is set and enable is sampled low while the channel runs, the output is low from the next clock onward.
- R9: When control bit 6 is clear and enable is sampled low while the channel runs, the current period finishes unchanged and the output then stays low.
- R10: New duty, period and prescale values written while the channel runs take effect at the start of the next period.
- R11: The outputs are low after reset and stay low while the channel is disabled, whatever the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| ch_en | input | NUM_CH | Run enable, one bit per channel |
| pwm_out | output | NUM_CH | Modulated output, one bit per channel |

## Verification
Wrong counter or shadow state in this block shows up directly on the output pins, within one period. A prescale or period counter that overruns its limit makes a period too long. A shadow register that reloads in the middle of a period cuts a pulse short. A wrong stop decision leaves the output high one clock after enable falls in abrupt mode, or drops it early in graceful mode. For these reasons the bench compares every output clock of every period against a waveform computed from the register values, instead of only sampling pulse widths.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // word index of each register inside one channel window
   localparam logic [1:0] WIX_CTRL = 2'd0;
   localparam logic [1:0] WIX_DUTY = 2'd1;
   localparam logic [1:0] WIX_PER  = 2'd2;
   // address bit that selects the channel window (stride 0x10)
   localparam int CH_SEL_BIT = 4;
   localparam int BUS_W      = 32;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] div_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) div_cnt <= '0;
      else if (div_cnt == limit) div_cnt <= '0;
      else div_cnt <= div_cnt + 1'b1;
   end

   assign tick = !clear && (div_cnt == limit);

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> div_cnt <= limit); // R3
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int PRE_W = 6,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             abrupt,
   input  logic [PRE_W-1:0] cfg_pre,
   input  logic [CNT_W-1:0] cfg_pv,
   input  logic [CNT_W-1:0] cfg_dc,
   input  logic             cfg_fd,
   output logic             out
);
   logic             running;
   logic [CNT_W-1:0] per_cnt;
   logic [PRE_W-1:0] act_pre;
   logic [CNT_W-1:0] act_pv;
   logic [CNT_W-1:0] act_dc;
   logic             act_fd;
   logic             tick;
   logic             cut;
   logic             wrap;

   assign cut  = running && !en && abrupt;
   assign wrap = tick && (per_cnt == act_pv);

   pwm_prescaler #(.PRE_W(PRE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!running || cut),
      .limit (act_pre),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         per_cnt <= '0;
         act_pre <= '0;
         act_pv  <= '0;
         act_dc  <= '0;
         act_fd  <= 1'b0;
      end else if (!running) begin
         per_cnt <= '0;
         if (en) begin
            running <= 1'b1;
            act_pre <= cfg_pre;
            act_pv  <= cfg_pv;
            act_dc  <= cfg_dc;
            act_fd  <= cfg_fd;
         end
      end else if (cut) begin
         running <= 1'b0;
         per_cnt <= '0;
      end else if (wrap) begin
         per_cnt <= '0;
         if (en) begin
            act_pre <= cfg_pre;
            act_pv  <= cfg_pv;
            act_dc  <= cfg_dc;
            act_fd  <= cfg_fd;
         end else begin
            running <= 1'b0;
         end
      end else if (tick) begin
         per_cnt <= per_cnt + 1'b1;
      end
   end

   assign out = running && (act_fd || (per_cnt < act_dc));

   AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> per_cnt <= act_pv); // R3
   AST_ABRUPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !en && abrupt) |=> !out); // R8
   AST_GRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !en && !abrupt && !wrap) |=> running); // R9
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !wrap) |=> ($stable(act_dc) && $stable(act_pv) && $stable(act_fd))); // R10
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
   import pwm_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int PRE_W  = 6,
   parameter int CNT_W  = 10,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [NUM_CH-1:0] ch_en,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int CTRL_W = PRE_W + 1;
   localparam int DUTY_W = CNT_W + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("NUM_CH must be 1 or 2");
      end
      if (ADDR_W < CH_SEL_BIT + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for channel windows");
      end
      if (DUTY_W > BUS_W || CTRL_W > BUS_W) begin : g_bad_w
         $error("register fields wider than data bus");
      end
   endgenerate

   logic [BUS_W-1:0] rd_word [NUM_CH];
   logic             unused_bits;
   assign unused_bits = &{1'b0, wdata};

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         logic [CTRL_W-1:0] ctrl_q;
         logic [DUTY_W-1:0] duty_q;
         logic [CNT_W-1:0]  per_q;
         logic              win;

         assign win = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:CH_SEL_BIT] == c);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ctrl_q <= '0;
               duty_q <= '0;
               per_q  <= '0;
            end else if (wr_en && win) begin
               case (addr[3:2])
                  WIX_CTRL: ctrl_q <= wdata[CTRL_W-1:0];
                  WIX_DUTY: duty_q <= wdata[DUTY_W-1:0];
                  WIX_PER:  per_q  <= wdata[CNT_W-1:0];
                  default:  ;
               endcase
            end
         end

         always_comb begin
            rd_word[c] = '0;
            if (win) begin
               case (addr[3:2])
                  WIX_CTRL: rd_word[c] = BUS_W'(ctrl_q);
                  WIX_DUTY: rd_word[c] = BUS_W'(duty_q);
                  WIX_PER:  rd_word[c] = BUS_W'(per_q);
                  default:  rd_word[c] = '0;
               endcase
            end
         end

         pwm_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[c]),
            .abrupt  (ctrl_q[PRE_W]),
            .cfg_pre (ctrl_q[PRE_W-1:0]),
            .cfg_pv  (per_q),
            .cfg_dc  (duty_q[CNT_W-1:0]),
            .cfg_fd  (duty_q[CNT_W]),
            .out     (pwm_out[c])
         );

         AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[c] && !pwm_out[c]) |=> !pwm_out[c]); // R11
      end
   endgenerate

   logic [BUS_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_CH; k++) rd_mux = rd_mux | rd_word[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R1
endmodule

// File: tb/pwm_prescaled_bench.sv
module pwm_prescaled_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  ch_en = '0;
   logic [1:0]  pwm_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct { int ch; bit val; int req; } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   pwm_prescaled u_pwm_prescaled (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ch_en(ch_en), .pwm_out(pwm_out)
   );

   // monitor: sample 5 ns after each rising edge
   always @(posedge clk) begin
      #5;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (pwm_out[e.ch] !== e.val) begin
            bad++;
            $display("FAIL R%0d ch%0d pwm_out actual=%0b expected=%0b at %0t",
                     e.req, e.ch, pwm_out[e.ch], e.val, $time);
         end
      end
   end

   task automatic push_bit(int ch, bit v, int req);
      exp_t e;
      e.ch = ch; e.val = v; e.req = req;
      q.push_back(e);
   endtask

   task automatic push_period(int ch, int pre, int pv, int dc, bit fd, int req);
      for (int j = 0; j < (pre + 1) * (pv + 1); j++)
         push_bit(ch, fd || (j / (pre + 1) < dc), req);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(logic [4:0] a, logic [31:0] exp, string req);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      total++;
      if (rdata !== exp) begin
         bad++;
         $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", req, a, rdata, exp);
      end
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic setup(int ch, int pre, bit abr, int pv, int dc, bit fd);
      logic [4:0] base;
      base = (ch == 1) ? 5'h10 : 5'h00;
      wr(base + 5'h0, 32'(pre) | (32'(abr) << 6));
      wr(base + 5'h4, 32'(dc) | (32'(fd) << 10));
      wr(base + 5'h8, 32'(pv));
   endtask

   // enable, run whole periods, graceful stop, then expect idle
   task automatic run_grace(int ch, int pre, int pv, int dc, bit fd, int periods, int req);
      int len;
      len = (pre + 1) * (pv + 1);
      setup(ch, pre, 1'b0, pv, dc, fd);
      ch_en[ch] = 1'b1;
      for (int p = 0; p < periods; p++) push_period(ch, pre, pv, dc, fd, req);
      for (int z = 0; z < 3; z++) push_bit(ch, 1'b0, 9);   // R9 idle after stop
      repeat (periods * len) @(negedge clk);
      ch_en[ch] = 1'b0;
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      total++;
      if (pwm_out !== 2'b00) begin
         bad++;
         $display("FAIL R11 reset pwm_out actual=%b expected=00", pwm_out);
      end
      rd_check(5'h00, 32'h0, "R1");

      // R1: readback with unused bits zero
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h0C, 32'hFFFF_FFFF);
      rd_check(5'h00, 32'h7F, "R1");
      rd_check(5'h04, 32'h7FF, "R1");
      rd_check(5'h08, 32'h3FF, "R1");
      rd_check(5'h0C, 32'h0, "R1");

      // R2: second channel window
      wr(5'h10, 32'h15);
      wr(5'h14, 32'h123);
      wr(5'h18, 32'h2AB);
      rd_check(5'h10, 32'h15, "R2");
      rd_check(5'h14, 32'h123, "R2");
      rd_check(5'h18, 32'h2AB, "R2");
      rd_check(5'h00, 32'h7F, "R2");

      // R11: registers loaded, enable low, output stays low
      for (int z = 0; z < 20; z++) push_bit(0, 1'b0, 11);
      for (int z = 0; z < 20; z++) push_bit(1, 1'b0, 11);
      drain();

      // R3 R4: prescale 1, period 4, duty 2 -> 10 clocks, 4 high
      run_grace(0, 1, 4, 2, 1'b0, 2, 4);
      // R5: zero duty
      run_grace(0, 0, 3, 0, 1'b0, 2, 5);
      // R6: force-on flag overrides zero compare
      run_grace(0, 0, 3, 0, 1'b1, 2, 6);
      // R7: compare beyond period
      run_grace(0, 0, 3, 7, 1'b0, 2, 7);
      // R3 with larger prescale on channel 1 (R2)
      run_grace(1, 2, 2, 1, 1'b0, 2, 3);

      // R8: abrupt stop after 7 clocks of an 18-clock period
      setup(0, 2, 1'b1, 5, 4, 1'b0);
      ch_en[0] = 1'b1;
      for (int j = 0; j < 7; j++) push_bit(0, (j / 3) < 4, 8);
      for (int z = 0; z < 12; z++) push_bit(0, 1'b0, 8);
      repeat (7) @(negedge clk);
      ch_en[0] = 1'b0;
      drain();

      // R10: duty rewritten mid-period applies to the next period only
      setup(0, 0, 1'b0, 7, 2, 1'b0);
      ch_en[0] = 1'b1;
      push_period(0, 0, 7, 2, 1'b0, 10);
      push_period(0, 0, 7, 6, 1'b0, 10);
      for (int z = 0; z < 3; z++) push_bit(0, 1'b0, 9);
      repeat (3) @(negedge clk);
      wr(5'h04, 32'd6);
      repeat (2 * 8 - 4) @(negedge clk);
      ch_en[0] = 1'b0;
      drain();

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule